// File: doc/BRIEF.md
# Pixel Column Hit Scanner with Edge Timestamps

This block is the digital side of one column of a hybrid pixel readout. A free-running time code, `TS_W` bits wide, is broadcast to every pixel in the column. Each pixel watches its own discriminator bit. It latches the broadcast code when the bit rises and again when it falls. From the two stamps a downstream stage can recover the pulse width, which is a coarse measure of the deposited charge.

Pixels that hold a complete hit are found by a ripple priority chain running toward the column end. The lowest-numbered complete pixel wins. Its row number and both stamps move into a single output register with a valid/ready handshake. The pixel is cleared in the same cycle, so each hit leaves the column exactly once. A per-pixel mask bit stops a pixel from starting a new hit. The output also carries the pulse width, taken modulo 2^`TS_W`.

Top module: `pxcol_top`

## Requirements
- R1: While `rst_ni` is low and after it is released with no stimulus, `out_valid_o` is 0 and no pixel holds a hit.
- R2: The leading stamp of a hit equals `ts_i` at the first rising clock edge where the pixel's `disc_i` bit is sampled 1 after having been sampled 0.
- R3: The trailing stamp equals `ts_i` at the first rising clock edge where that bit is sampled 0 again.
- R4: A pixel with a leading stamp but no trailing stamp is never presented at the output.
- R5: When several pixels hold complete hits, the one with the lowest row index is loaded first, and the others follow in ascending row order.
- R6: A pixel is cleared in the cycle its hit is loaded into the output register, so each hit appears at the output exactly once.
- R7: A pixel whose `mask_i` bit is 1 ignores a rising discriminator edge and records no hit.
- R8: A rising discriminator edge on a pixel that holds a complete, unread hit is ignored. The stored stamps are kept and no second hit is recorded.
- R9: `out_width_o` equals `out_trail_o - out_lead_o` modulo 2^`TS_W`, including when the time code wraps between the two edges.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_row_o`, `out_lead_o`, `out_trail_o` and `out_width_o` hold their values.
- R11: If the output register is empty, a hit completed at clock edge k is presented with `out_valid_o` = 1 after clock edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Column clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts_i | input | TS_W (7) | Broadcast time code |
| disc_i | input | ROWS (160) | Discriminator output per pixel, bit i is row i |
| mask_i | input | ROWS (160) | Per-pixel hit suppression, 1 = masked |
| out_valid_o | output | 1 | Output register holds a hit |
| out_ready_i | input | 1 | Consumer accepts the hit this cycle |
| out_row_o | output | ROW_W (8) | Row index of the presented hit |
| out_lead_o | output | TS_W (7) | Leading-edge stamp |
| out_trail_o | output | TS_W (7) | Trailing-edge stamp |
| out_width_o | output | TS_W (7) | Trailing minus leading, modulo 2^TS_W |

## Verification
The assertions run on every cycle and cover four properties. They check that a stalled output holds steady, and that an empty output register picks up a pending complete hit in the next cycle. They also check that each freshly loaded row has no lower-numbered complete pixel behind it, and that the loaded pixel is cleared at the same edge. The exact edge at which each stamp is captured, the wrap of the width, masking, the refusal of half-finished pulses, and the dropping of a retrigger on an unread pixel depend on the stimulus. These are shown only by the directed scenarios, which compare the output fields against values predicted from the time code the bench drives.

// File: rtl/pxcol_pkg.sv
package pxcol_pkg;
  typedef enum logic [1:0] {
    PX_IDLE  = 2'd0,
    PX_ARMED = 2'd1,
    PX_DONE  = 2'd2
  } px_state_e;
endpackage

// File: rtl/pxcol_pixel.sv
module pxcol_pixel
  import pxcol_pkg::*;
#(
  parameter int TS_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            disc_i,
  input  logic            mask_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            clr_i,
  output logic            done_o,
  output logic [TS_W-1:0] lead_o,
  output logic [TS_W-1:0] trail_o
);
  px_state_e       state_q;
  logic            disc_q;
  logic            rise, fall;
  logic [TS_W-1:0] lead_q, trail_q;

  assign rise = disc_i & ~disc_q;
  assign fall = ~disc_i & disc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disc_q  <= 1'b0;
      state_q <= PX_IDLE;
      lead_q  <= '0;
      trail_q <= '0;
    end else begin
      disc_q <= disc_i;
      case (state_q)
        PX_IDLE: if (rise && !mask_i) begin
          lead_q  <= ts_i;
          state_q <= PX_ARMED;
        end
        PX_ARMED: if (fall) begin
          trail_q <= ts_i;
          state_q <= PX_DONE;
        end
        // edges ignored until the hit has been read
        PX_DONE: if (clr_i) state_q <= PX_IDLE;
        default: state_q <= PX_IDLE;
      endcase
    end
  end

  assign done_o  = (state_q == PX_DONE);
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/pxcol_scan.sv
module pxcol_scan #(
  parameter int ROWS  = 160,
  parameter int TS_W  = 7,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic [ROWS-1:0] done_i,
  input  logic [TS_W-1:0] lead_i  [ROWS],
  input  logic [TS_W-1:0] trail_i [ROWS],
  output logic [ROWS-1:0] grant_o,
  output logic            any_o,
  output logic [ROW_W-1:0] row_o,
  output logic [TS_W-1:0] lead_o,
  output logic [TS_W-1:0] trail_o
);
  // ripple: a complete pixel blocks every row above it
  logic [ROWS:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < ROWS; g++) begin : g_chain
    assign grant_o[g]   = done_i[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | done_i[g];
  end

  assign any_o = blocked[ROWS];

  always_comb begin
    row_o   = '0;
    lead_o  = '0;
    trail_o = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (grant_o[i]) begin
        row_o   = row_o | ROW_W'(i);
        lead_o  = lead_o | lead_i[i];
        trail_o = trail_o | trail_i[i];
      end
    end
  end
endmodule

// File: rtl/pxcol_out.sv
module pxcol_out #(
  parameter int TS_W  = 7,
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [TS_W-1:0]  lead_i,
  input  logic [TS_W-1:0]  trail_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             valid_o,
  output logic [ROW_W-1:0] row_o,
  output logic [TS_W-1:0]  lead_o,
  output logic [TS_W-1:0]  trail_o,
  output logic [TS_W-1:0]  width_o
);
  logic free;

  assign free   = ~valid_o | ready_i;
  assign load_o = any_i & free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      row_o   <= '0;
      lead_o  <= '0;
      trail_o <= '0;
      width_o <= '0;
    end else begin
      if (free) valid_o <= any_i;
      if (load_o) begin
        row_o   <= row_i;
        lead_o  <= lead_i;
        trail_o <= trail_i;
        width_o <= trail_i - lead_i;  // wraps modulo 2^TS_W
      end
    end
  end
endmodule

// File: rtl/pxcol_top.sv
module pxcol_top #(
  parameter int ROWS  = 160,
  parameter int TS_W  = 7,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [ROWS-1:0]  disc_i,
  input  logic [ROWS-1:0]  mask_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [ROW_W-1:0] out_row_o,
  output logic [TS_W-1:0]  out_lead_o,
  output logic [TS_W-1:0]  out_trail_o,
  output logic [TS_W-1:0]  out_width_o
);
  logic [ROWS-1:0]  done_w, grant_w, clr_w;
  logic [TS_W-1:0]  lead_w  [ROWS];
  logic [TS_W-1:0]  trail_w [ROWS];
  logic             any_w, load_w;
  logic [ROW_W-1:0] sel_row;
  logic [TS_W-1:0]  sel_lead, sel_trail;

  for (genvar g = 0; g < ROWS; g++) begin : g_px
    assign clr_w[g] = grant_w[g] & load_w;
    pxcol_pixel #(.TS_W(TS_W)) u_px (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .disc_i (disc_i[g]),
      .mask_i (mask_i[g]),
      .ts_i   (ts_i),
      .clr_i  (clr_w[g]),
      .done_o (done_w[g]),
      .lead_o (lead_w[g]),
      .trail_o(trail_w[g])
    );
  end

  pxcol_scan #(.ROWS(ROWS), .TS_W(TS_W), .ROW_W(ROW_W)) u_scan (
    .done_i (done_w),
    .lead_i (lead_w),
    .trail_i(trail_w),
    .grant_o(grant_w),
    .any_o  (any_w),
    .row_o  (sel_row),
    .lead_o (sel_lead),
    .trail_o(sel_trail)
  );

  pxcol_out #(.TS_W(TS_W), .ROW_W(ROW_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .any_i  (any_w),
    .row_i  (sel_row),
    .lead_i (sel_lead),
    .trail_i(sel_trail),
    .ready_i(out_ready_i),
    .load_o (load_w),
    .valid_o(out_valid_o),
    .row_o  (out_row_o),
    .lead_o (out_lead_o),
    .trail_o(out_trail_o),
    .width_o(out_width_o)
  );
endmodule

// File: rtl/pxcol_chk.sv
module pxcol_chk #(
  parameter int ROWS  = 160,
  parameter int TS_W  = 7,
  parameter int ROW_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ROWS-1:0]  done_i,
  input logic             out_valid_i,
  input logic             out_ready_i,
  input logic [ROW_W-1:0] out_row_i,
  input logic [TS_W-1:0]  out_lead_i,
  input logic [TS_W-1:0]  out_trail_i,
  input logic [TS_W-1:0]  out_width_i
);
  logic [ROWS-1:0] below;
  logic            was_free;

  always_comb begin
    for (int i = 0; i < ROWS; i++) below[i] = (i < int'(out_row_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) was_free <= 1'b1;
    else         was_free <= ~out_valid_i | out_ready_i;
  end

  a_r10_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_row_i) &&
      $stable(out_lead_i) && $stable(out_trail_i) && $stable(out_width_i)));

  a_r11_pickup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_i && (done_i != '0)) |=> out_valid_i);

  a_r5_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_free && out_valid_i) |-> (($past(done_i) & below) == '0));

  a_r6_cleared_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_free && out_valid_i) |-> !done_i[out_row_i]);
endmodule

bind pxcol_top pxcol_chk #(.ROWS(ROWS), .TS_W(TS_W), .ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_i     (done_w),
  .out_valid_i(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_row_i  (out_row_o),
  .out_lead_i (out_lead_o),
  .out_trail_i(out_trail_o),
  .out_width_i(out_width_o)
);

// File: tb/sim_pxcol_top.sv
`timescale 1ns/1ps
module sim_pxcol_top;
  localparam int ROWS = 160;
  localparam int TS_W = 7;
  localparam int ROW_W = $clog2(ROWS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TS_W-1:0]  ts = '0;
  logic [ROWS-1:0]  disc = '0;
  logic [ROWS-1:0]  mask = '0;
  logic             ready = 1'b0;
  logic             valid;
  logic [ROW_W-1:0] row;
  logic [TS_W-1:0]  lead, trail, width;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pxcol_top #(.ROWS(ROWS), .TS_W(TS_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ts_i(ts), .disc_i(disc), .mask_i(mask),
    .out_valid_o(valid), .out_ready_i(ready), .out_row_o(row),
    .out_lead_o(lead), .out_trail_o(trail), .out_width_o(width)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      ts = ts + 1'b1;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_hit(input string req, input int r, input int l, input int t);
    check({req, " valid"}, int'(valid), 1);
    check({req, " row"}, int'(row), r);
    check({req, " lead"}, int'(lead), l);
    check({req, " trail"}, int'(trail), t);
    check({req, " width"}, int'(width), (t - l) & 127);
  endtask

  task automatic t_reset;
    check("R1 valid during reset", int'(valid), 0);
    rst_n = 1'b1;
    step(3);
    check("R1 valid after reset", int'(valid), 0);
  endtask

  task automatic t_single;
    int l, t;
    ready = 1'b1;
    disc[5] = 1'b1; l = ts; step();
    step(3);
    disc[5] = 1'b0; t = ts; step();
    check("R11 not yet presented", int'(valid), 0);
    step();
    check_hit("R2 R3 R11 single", 5, l, t);
    step();
    check("R6 read once", int'(valid), 0);
  endtask

  task automatic t_wrap;
    int l, t;
    ready = 1'b1;
    ts = 7'd120;
    disc[0] = 1'b1; l = ts; step();
    step(9);
    disc[0] = 1'b0; t = ts; step();
    step();
    check_hit("R9 wrap", 0, l, t);
    check("R9 wrap width", int'(width), 10);
    step();
  endtask

  task automatic t_incomplete;
    int l, t;
    ready = 1'b1;
    disc[7] = 1'b1; l = ts; step();
    step(6);
    check("R4 half hit hidden", int'(valid), 0);
    disc[7] = 1'b0; t = ts; step(2);
    check_hit("R4 after trail", 7, l, t);
    step();
  endtask

  task automatic t_priority;
    int l, t;
    ready = 1'b0;
    disc[30] = 1'b1; disc[2] = 1'b1; disc[159] = 1'b1; l = ts; step();
    disc[30] = 1'b0; disc[2] = 1'b0; disc[159] = 1'b0; t = ts; step();
    step();
    check_hit("R5 first lowest", 2, l, t);
    step(3);
    check_hit("R10 held under stall", 2, l, t);
    ready = 1'b1;
    step();
    check_hit("R5 second", 30, l, t);
    step();
    check_hit("R5 third", 159, l, t);
    step();
    check("R6 column drained", int'(valid), 0);
  endtask

  task automatic t_mask;
    int l, t;
    ready = 1'b1;
    mask[9] = 1'b1;
    disc[9] = 1'b1; step(2);
    disc[9] = 1'b0; step(4);
    check("R7 masked pulse dropped", int'(valid), 0);
    mask[9] = 1'b0;
    step();
    disc[9] = 1'b1; l = ts; step();
    disc[9] = 1'b0; t = ts; step(2);
    check_hit("R7 unmasked pulse", 9, l, t);
    step();
    check("R7 no stale masked hit", int'(valid), 0);
  endtask

  task automatic t_retrigger;
    int l1, t1, l3, t3;
    ready = 1'b0;
    disc[1] = 1'b1; l1 = ts; step();
    disc[1] = 1'b0; t1 = ts; step(2);
    check_hit("R8 occupier", 1, l1, t1);
    disc[3] = 1'b1; l3 = ts; step(2);
    disc[3] = 1'b0; t3 = ts; step(2);
    disc[3] = 1'b1; step(3);
    disc[3] = 1'b0; step(2);
    ready = 1'b1;
    step();
    check_hit("R8 first stamps kept", 3, l3, t3);
    step();
    check("R8 second pulse dropped", int'(valid), 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_wrap();
    t_incomplete();
    t_priority();
    t_mask();
    t_retrigger();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule